// File: doc/BRIEF.md
# Phase Detector with Pump and Lock Control

This block is the digital heart of one synthesizer channel. It compares a divided reference pulse stream against a divided oscillator pulse stream and turns the phase difference into up and down pump requests. All signals are synchronous to one system clock, and both input streams arrive as single-cycle pulses.

Around the detector sits the control logic that the analog pump needs:
- a sense swap for oscillators whose tuning slope is negative;
- a forced high-impedance state;
- a current magnitude select, where the high setting is four times the low one;
- a powerdown that only takes hold once the pump is quiet.

A lock monitor counts consecutive comparisons whose pulse width stays inside a programmable window. A single multiplexed status pin can show one of several things: lock, combined lock with a peer channel, either input stream, or the state of the fast-lock resistor switch. It can also be held low.

Fast acquisition is entered by selecting the fast-lock status function and raising the current bit. The block then closes the damping-resistor switch and selects the high current. Leaving fast acquisition, and any lowering of the current, waits until the pump is idle, so the loop filter charge sees no glitch.

Top module: `pfd_lock_ctrl`

## Requirements
- R1: A reference pulse raises the internal up request, and an oscillator pulse raises the internal down request. Each request is held until the other stream pulses. The one-sided request lasts exactly as many clock cycles as the lead of one pulse over the other.
- R2: When both internal requests are high together, both clear on the next clock edge unless a new input pulse arrives in that cycle. Pulses that arrive in the same cycle therefore give one cycle of both requests and zero one-sided width.
- R3: With `pol_pos` = 1, `pump_up` follows the internal up request and `pump_dn` follows the internal down request. With `pol_pos` = 0 the two outputs are swapped.
- R4: `tri_req` = 1 raises `pump_hiz` at once. While `pump_hiz` is 1, `pump_up` and `pump_dn` stay 0.
- R5: `cur_x4` (1 = high current, four times the low one) rises one edge after `cur_hi` rises. After `cur_hi` falls, `cur_x4` falls only on an edge at which both internal requests are low.
- R6: A request on `pwdn_req` sets `pwr_down` only on an edge at which both internal requests are low or `tri_req` is 1. Dropping `pwdn_req` clears `pwr_down` on the next edge. While `pwr_down` is 1:
  - `pump_hiz` is 1;
  - the detector and the lock state are held cleared;
  - input pulses produce no pump request.
- R7: `lock` rises on the edge after the `LOCK_N`-th consecutive comparison whose one-sided width is at most `lock_win` (the equal case counts as inside).
- R8: One comparison with a one-sided width above `lock_win` clears `lock` and the consecutive count.
- R9: In lock mode (`stat_sel` = 1), `stat_out` is `lock` with low pulses while any internal request is high. In combined mode (`stat_sel` = 2), `stat_out` is additionally ANDed with `peer_lock`. The status output is registered, so it lags by one edge.
- R10: With `stat_sel` = 0, 6 or 7, `stat_out` is driven low on the next edge.
- R11: With `stat_sel` = 3, `stat_out` repeats `ref_pulse` one edge later. With `stat_sel` = 4, it repeats `fb_pulse` one edge later.
- R12: Fast-lock mode uses `stat_sel` = 5.
  - `fl_sw` rises one edge after `cur_hi` is 1 in this mode.
  - After the mode or `cur_hi` drops, `fl_sw` falls only on an edge at which both internal requests are low.
  - In this mode, `stat_out` is the inverse of `fl_sw`, one edge later.
- R13: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_pulse | input | 1 | Single-cycle divided reference pulse |
| fb_pulse | input | 1 | Single-cycle divided oscillator pulse |
| pol_pos | input | 1 | 1: oscillator frequency rises with tuning voltage |
| tri_req | input | 1 | Force pump output to high impedance |
| cur_hi | input | 1 | Request high pump current |
| pwdn_req | input | 1 | Powerdown request |
| stat_sel | input | 3 | Status function: 0 off, 1 lock, 2 combined lock, 3 reference, 4 oscillator, 5 fast-lock, 6/7 off |
| lock_win | input | WIDTH_W | Largest one-sided width, in clock cycles, counted as in lock |
| peer_lock | input | 1 | Lock flag of the other channel |
| pump_up | output | 1 | Pump source request |
| pump_dn | output | 1 | Pump sink request |
| pump_hiz | output | 1 | Pump output high impedance |
| cur_x4 | output | 1 | High current selected |
| lock | output | 1 | Lock indicator |
| fl_sw | output | 1 | Damping-resistor switch closed to ground |
| stat_out | output | 1 | Multiplexed status pin |
| pwr_down | output | 1 | Channel powered down |

## Verification
The detector is driven with four kinds of pulse pair:
- reference leading by several widths, which checks the up path and the width count;
- oscillator leading, which checks the down path;
- coincident pulses, which leave only the one-cycle reset overlap;
- the same pairs with the sense bit low, which separates polarity swapping from detector direction.

A run of widths below, equal to and above the window shows the count-to-lock, the inclusive boundary and the single-miss loss.

Mode changes are each applied once with the pump idle and once with a request in flight. This shows which changes are immediate and which wait for an idle pump: tri-state, current fall, fast-lock exit and powerdown.

// File: rtl/pfd_ctl_pkg.sv
package pfd_ctl_pkg;

    // Status pin function select
    typedef enum logic [2:0] {
        STAT_OFF  = 3'd0,
        STAT_LOCK = 3'd1,
        STAT_BOTH = 3'd2,
        STAT_REF  = 3'd3,
        STAT_FB   = 3'd4,
        STAT_FAST = 3'd5
    } stat_mode_e;

endpackage

// File: rtl/pfd_core.sv
module pfd_core #(
    parameter int WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_i,
    input  logic               fb_i,
    input  logic               clr_i,
    output logic               up_o,
    output logic               dn_o,
    output logic               done_o,
    output logic [WIDTH_W-1:0] width_o
);

    localparam logic [WIDTH_W-1:0] WIDTH_MAX = '1;

    typedef struct packed {
        logic               up;
        logic               dn;
        logic [WIDTH_W-1:0] width;
    } core_t;

    core_t st_q, st_d;
    logic  both, single;

    always_comb begin
        both   = st_q.up & st_q.dn;
        single = st_q.up ^ st_q.dn;
        st_d   = st_q;
        if (clr_i) begin
            st_d = '0;
        end else begin
            st_d.up = ref_i | (st_q.up & ~both);
            st_d.dn = fb_i  | (st_q.dn & ~both);
            if (both) begin
                st_d.width = '0;
            end else if (single && st_q.width != WIDTH_MAX) begin
                st_d.width = st_q.width + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign up_o    = st_q.up;
    assign dn_o    = st_q.dn;
    assign done_o  = both;
    assign width_o = st_q.width;

endmodule

// File: rtl/pfd_lock_det.sv
module pfd_lock_det #(
    parameter int WIDTH_W = 8,
    parameter int LOCK_N  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               done_i,
    input  logic [WIDTH_W-1:0] width_i,
    input  logic [WIDTH_W-1:0] win_i,
    output logic               lock_o
);

    localparam int               CNT_W = (LOCK_N > 1) ? $clog2(LOCK_N) : 1;
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(LOCK_N - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             lock;
    } det_t;

    det_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else if (done_i) begin
            if (width_i <= win_i) begin
                if (st_q.cnt >= LAST) st_d.lock = 1'b1;
                else                  st_d.cnt  = st_q.cnt + 1'b1;
            end else begin
                st_d = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lock_o = st_q.lock;

endmodule

// File: rtl/pfd_pump_ctrl.sv
module pfd_pump_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic up_i,
    input  logic dn_i,
    input  logic pol_pos_i,
    input  logic tri_i,
    input  logic cur_hi_i,
    input  logic fast_sel_i,
    input  logic pwdn_i,
    output logic pump_up_o,
    output logic pump_dn_o,
    output logic hiz_o,
    output logic cur_x4_o,
    output logic fl_o,
    output logic pd_o
);

    typedef struct packed {
        logic pd;
        logic cur;
        logic fl;
    } pump_t;

    pump_t st_q, st_d;
    logic  idle;

    always_comb begin
        idle = ~up_i & ~dn_i;
        st_d = st_q;
        // powerdown waits for a quiet or tri-stated pump
        st_d.pd  = pwdn_i & (st_q.pd | idle | tri_i);
        // raising is immediate, lowering waits for a quiet pump
        st_d.cur = cur_hi_i | (st_q.cur & ~idle);
        st_d.fl  = (fast_sel_i & cur_hi_i) | (st_q.fl & ~idle);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hiz_o     = tri_i | st_q.pd;
    assign pump_up_o = ~hiz_o & (pol_pos_i ? up_i : dn_i);
    assign pump_dn_o = ~hiz_o & (pol_pos_i ? dn_i : up_i);
    assign cur_x4_o  = st_q.cur;
    assign fl_o      = st_q.fl;
    assign pd_o      = st_q.pd;

endmodule

// File: rtl/pfd_stat_mux.sv
module pfd_stat_mux
    import pfd_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel_i,
    input  logic       lock_i,
    input  logic       peer_i,
    input  logic       busy_i,
    input  logic       ref_i,
    input  logic       fb_i,
    input  logic       fl_i,
    output logic       stat_o
);

    typedef struct packed {
        logic stat;
    } stat_t;

    stat_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        case (stat_mode_e'(sel_i))
            STAT_LOCK: st_d.stat = lock_i & ~busy_i;
            STAT_BOTH: st_d.stat = lock_i & peer_i & ~busy_i;
            STAT_REF:  st_d.stat = ref_i;
            STAT_FB:   st_d.stat = fb_i;
            STAT_FAST: st_d.stat = ~fl_i;
            default:   st_d.stat = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.stat;

endmodule

// File: rtl/pfd_lock_ctrl.sv
module pfd_lock_ctrl
    import pfd_ctl_pkg::*;
#(
    parameter int WIDTH_W = 8,
    parameter int LOCK_N  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_pulse,
    input  logic               fb_pulse,
    input  logic               pol_pos,
    input  logic               tri_req,
    input  logic               cur_hi,
    input  logic               pwdn_req,
    input  logic [2:0]         stat_sel,
    input  logic [WIDTH_W-1:0] lock_win,
    input  logic               peer_lock,
    output logic               pump_up,
    output logic               pump_dn,
    output logic               pump_hiz,
    output logic               cur_x4,
    output logic               lock,
    output logic               fl_sw,
    output logic               stat_out,
    output logic               pwr_down
);

    logic               pfd_up, pfd_dn, cmp_done;
    logic [WIDTH_W-1:0] cmp_width;
    logic               fast_sel;

    assign fast_sel = (stat_mode_e'(stat_sel) == STAT_FAST);

    pfd_core #(.WIDTH_W(WIDTH_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_i   (ref_pulse),
        .fb_i    (fb_pulse),
        .clr_i   (pwr_down),
        .up_o    (pfd_up),
        .dn_o    (pfd_dn),
        .done_o  (cmp_done),
        .width_o (cmp_width)
    );

    pfd_lock_det #(.WIDTH_W(WIDTH_W), .LOCK_N(LOCK_N)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (pwr_down),
        .done_i  (cmp_done),
        .width_i (cmp_width),
        .win_i   (lock_win),
        .lock_o  (lock)
    );

    pfd_pump_ctrl u_pump (
        .clk        (clk),
        .rst_n      (rst_n),
        .up_i       (pfd_up),
        .dn_i       (pfd_dn),
        .pol_pos_i  (pol_pos),
        .tri_i      (tri_req),
        .cur_hi_i   (cur_hi),
        .fast_sel_i (fast_sel),
        .pwdn_i     (pwdn_req),
        .pump_up_o  (pump_up),
        .pump_dn_o  (pump_dn),
        .hiz_o      (pump_hiz),
        .cur_x4_o   (cur_x4),
        .fl_o       (fl_sw),
        .pd_o       (pwr_down)
    );

    pfd_stat_mux u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (stat_sel),
        .lock_i (lock),
        .peer_i (peer_lock),
        .busy_i (pfd_up | pfd_dn),
        .ref_i  (ref_pulse),
        .fb_i   (fb_pulse),
        .fl_i   (fl_sw),
        .stat_o (stat_out)
    );

endmodule

// File: rtl/pfd_lock_ctrl_chk.sv
module pfd_lock_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ref_pulse,
    input logic       fb_pulse,
    input logic       tri_req,
    input logic       pwdn_req,
    input logic [2:0] stat_sel,
    input logic       pfd_up,
    input logic       pfd_dn,
    input logic       pump_up,
    input logic       pump_dn,
    input logic       pump_hiz,
    input logic       cur_x4,
    input logic       fl_sw,
    input logic       stat_out,
    input logic       pwr_down,
    input logic       lock
);

    // R2: overlap of both requests lasts one cycle when no new pulse arrives
    assert_min_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pfd_up && pfd_dn && !ref_pulse && !fb_pulse) |=> !(pfd_up && pfd_dn));

    // R4: high impedance silences both pump requests
    assert_hiz_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pump_hiz |-> (!pump_up && !pump_dn));

    // R4: tri-state request shows at once
    assert_tri_hiz_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tri_req |-> pump_hiz);

    // R5: current falls only from an idle pump
    assert_cur_fall_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cur_x4) |-> $past(!pfd_up && !pfd_dn));

    // R6: powerdown enters only from a quiet or tri-stated pump
    assert_pd_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_down) |-> $past(tri_req || (!pfd_up && !pfd_dn)));

    // R6: release is one edge after the request drops
    assert_pd_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pwdn_req |=> !pwr_down);

    // R7: lock is only gained at the end of a comparison
    assert_lock_on_cmp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> $past(pfd_up && pfd_dn));

    // R10: disabled status pin is low
    assert_stat_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_sel == 3'd0) |=> !stat_out);

    // R12: fast-lock switch opens only from an idle pump
    assert_fast_exit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_sw) |-> $past(!pfd_up && !pfd_dn));

endmodule

bind pfd_lock_ctrl pfd_lock_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_pulse (ref_pulse),
    .fb_pulse  (fb_pulse),
    .tri_req   (tri_req),
    .pwdn_req  (pwdn_req),
    .stat_sel  (stat_sel),
    .pfd_up    (pfd_up),
    .pfd_dn    (pfd_dn),
    .pump_up   (pump_up),
    .pump_dn   (pump_dn),
    .pump_hiz  (pump_hiz),
    .cur_x4    (cur_x4),
    .fl_sw     (fl_sw),
    .stat_out  (stat_out),
    .pwr_down  (pwr_down),
    .lock      (lock)
);

// File: tb/pfd_lock_ctrl_test.sv
module pfd_lock_ctrl_test;

    localparam int WW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_pulse = 0, fb_pulse = 0, pol_pos = 1, tri_req = 0;
    logic          cur_hi = 0, pwdn_req = 0, peer_lock = 0;
    logic [2:0]    stat_sel = 3'd0;
    logic [WW-1:0] lock_win = 8'd2;
    logic          pump_up, pump_dn, pump_hiz, cur_x4, lock, fl_sw, stat_out, pwr_down;

    always #5 clk = ~clk;

    pfd_lock_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
        .pol_pos(pol_pos), .tri_req(tri_req), .cur_hi(cur_hi), .pwdn_req(pwdn_req),
        .stat_sel(stat_sel), .lock_win(lock_win), .peer_lock(peer_lock),
        .pump_up(pump_up), .pump_dn(pump_dn), .pump_hiz(pump_hiz), .cur_x4(cur_x4),
        .lock(lock), .fl_sw(fl_sw), .stat_out(stat_out), .pwr_down(pwr_down)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // scoreboard item: dir 0 = coincident, 1 = pump_up, 2 = pump_dn
    typedef struct {
        int    dir;
        int    width;
        string req;
    } ev_t;
    ev_t expq[$];

    task automatic chk(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push_ev(input int dir, input int width, input string req);
        ev_t e;
        e.dir = dir; e.width = width; e.req = req;
        expq.push_back(e);
    endtask

    // monitor: measure one-sided width per comparison, compare against queue
    int run_w = 0;
    int run_dir = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pump_up && pump_dn) begin
                n_chk++;
                if (expq.size() == 0) begin
                    n_fail++;
                    $display("FAIL R1 unexpected pump event: actual %0d/%0d expected none",
                             run_dir, run_w);
                end else begin
                    ev_t e;
                    e = expq.pop_front();
                    if (e.dir != run_dir || e.width != run_w) begin
                        n_fail++;
                        $display("FAIL %s pump dir/width: actual %0d/%0d expected %0d/%0d",
                                 e.req, run_dir, run_w, e.dir, e.width);
                    end
                end
                run_w = 0; run_dir = 0;
            end else if (pump_up) begin
                run_w++; run_dir = 1;
            end else if (pump_dn) begin
                run_w++; run_dir = 2;
            end
        end
    end

    // one comparison: lead pulse, then lag pulse d cycles later
    task automatic cmp_pair(input int d, input bit ref_first, input string req);
        int dir;
        dir = (d == 0) ? 0 : ((ref_first == pol_pos) ? 1 : 2);
        if (!pump_hiz) push_ev(dir, d, req);
        @(negedge clk);
        if (d == 0) begin
            ref_pulse = 1; fb_pulse = 1;
            @(negedge clk);
            ref_pulse = 0; fb_pulse = 0;
        end else begin
            if (ref_first) ref_pulse = 1; else fb_pulse = 1;
            @(negedge clk);
            ref_pulse = 0; fb_pulse = 0;
            repeat (d - 1) @(negedge clk);
            if (ref_first) fb_pulse = 1; else ref_pulse = 1;
            @(negedge clk);
            ref_pulse = 0; fb_pulse = 0;
        end
        repeat (3) @(negedge clk);
    endtask

    // status mirror of one input stream, closed by the other stream
    task automatic mirror(input bit use_ref, input string req);
        push_ev(use_ref ? 1 : 2, 2, req);
        stat_sel = use_ref ? 3'd3 : 3'd4;
        repeat (2) @(negedge clk);
        if (use_ref) ref_pulse = 1; else fb_pulse = 1;
        @(negedge clk);
        ref_pulse = 0; fb_pulse = 0;
        chk(req, stat_out, 1, "status mirrors pulse");
        @(negedge clk);
        chk(req, stat_out, 0, "status mirror back low");
        if (use_ref) fb_pulse = 1; else ref_pulse = 1;
        @(negedge clk);
        ref_pulse = 0; fb_pulse = 0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R13: reset state
        chk("R13", {pump_up, pump_dn, pump_hiz, cur_x4, lock, fl_sw, stat_out, pwr_down},
            0, "outputs after reset");

        // R1/R2 detector directions and widths, R7 count and boundary
        cmp_pair(3, 1, "R1");     // outside window
        cmp_pair(2, 0, "R1");     // good 1
        cmp_pair(0, 1, "R2");     // good 2
        chk("R7", lock, 0, "lock after two good");
        cmp_pair(1, 1, "R1");     // good 3
        chk("R7", lock, 0, "lock after three good");
        cmp_pair(2, 1, "R7");     // good 4, width equals window
        chk("R7", lock, 1, "lock after four good incl. boundary");

        // R9 lock and combined status
        stat_sel = 3'd1;
        repeat (2) @(negedge clk);
        chk("R9", stat_out, 1, "lock mode idle high");
        stat_sel = 3'd2; peer_lock = 0;
        repeat (2) @(negedge clk);
        chk("R9", stat_out, 0, "combined with peer unlocked");
        peer_lock = 1;
        repeat (2) @(negedge clk);
        chk("R9", stat_out, 1, "combined with peer locked");
        stat_sel = 3'd1;
        push_ev(1, 2, "R9");
        @(negedge clk); ref_pulse = 1;
        @(negedge clk); ref_pulse = 0;
        @(negedge clk);
        chk("R9", stat_out, 0, "lock mode low during pump pulse");
        fb_pulse = 1;
        @(negedge clk); fb_pulse = 0;
        repeat (3) @(negedge clk);
        chk("R9", stat_out, 1, "lock mode high again");

        // R8 single miss loses lock
        cmp_pair(5, 1, "R8");
        chk("R8", lock, 0, "lock lost after wide error");

        // R3 polarity swap
        pol_pos = 0;
        cmp_pair(2, 1, "R3");
        cmp_pair(1, 0, "R3");
        pol_pos = 1;

        // R10 disabled status versus a function that would be high
        stat_sel = 3'd5; cur_hi = 0;
        repeat (2) @(negedge clk);
        chk("R12", stat_out, 1, "fast-lock mode inactive high");
        stat_sel = 3'd0;
        repeat (2) @(negedge clk);
        chk("R10", stat_out, 0, "disabled status low");
        stat_sel = 3'd5;
        repeat (2) @(negedge clk);
        stat_sel = 3'd6;
        repeat (2) @(negedge clk);
        chk("R10", stat_out, 0, "unused select low");

        // R11 mirrors
        mirror(1, "R11");
        mirror(0, "R11");

        // R4 tri-state
        tri_req = 1;
        @(negedge clk);
        chk("R4", pump_hiz, 1, "tri-state raises hiz");
        ref_pulse = 1;
        @(negedge clk); ref_pulse = 0;
        @(negedge clk);
        chk("R4", {pump_up, pump_dn}, 0, "no request while hiz");
        fb_pulse = 1;
        @(negedge clk); fb_pulse = 0;
        repeat (3) @(negedge clk);
        tri_req = 0;
        @(negedge clk);
        chk("R4", pump_hiz, 0, "hiz released");

        // R5 current select outside fast-lock
        stat_sel = 3'd1; cur_hi = 1;
        @(negedge clk);
        chk("R5", cur_x4, 1, "high current selected");
        chk("R12", fl_sw, 0, "no switch outside fast-lock mode");
        cur_hi = 0;
        @(negedge clk);
        chk("R5", cur_x4, 0, "current drops when idle");

        // R12 fast-lock entry, exit deferred while busy
        stat_sel = 3'd5; cur_hi = 1;
        @(negedge clk);
        chk("R12", fl_sw, 1, "switch closes");
        @(negedge clk);
        chk("R12", stat_out, 0, "status low while fast-lock");
        push_ev(1, 2, "R12");
        ref_pulse = 1;
        @(negedge clk); ref_pulse = 0; cur_hi = 0;
        @(negedge clk);
        chk("R12", fl_sw, 1, "switch held while pump busy");
        chk("R5", cur_x4, 1, "current held while pump busy");
        fb_pulse = 1;
        @(negedge clk); fb_pulse = 0;
        repeat (3) @(negedge clk);
        chk("R12", fl_sw, 0, "switch opens after idle");
        chk("R5", cur_x4, 0, "current drops after idle");
        chk("R12", stat_out, 1, "status high after exit");

        // R6 relock, then powerdown requested while busy
        stat_sel = 3'd0;
        for (int i = 0; i < 4; i++) cmp_pair(1, 1, "R7");
        chk("R7", lock, 1, "relocked");
        push_ev(1, 2, "R6");
        @(negedge clk); ref_pulse = 1;
        @(negedge clk); ref_pulse = 0; pwdn_req = 1;
        @(negedge clk);
        chk("R6", pwr_down, 0, "powerdown deferred while busy");
        fb_pulse = 1;
        @(negedge clk); fb_pulse = 0;
        repeat (3) @(negedge clk);
        chk("R6", pwr_down, 1, "powerdown after idle");
        chk("R6", pump_hiz, 1, "hiz in powerdown");
        chk("R6", lock, 0, "lock cleared in powerdown");
        ref_pulse = 1;
        @(negedge clk); ref_pulse = 0;
        @(negedge clk);
        chk("R6", {pump_up, pump_dn}, 0, "no request in powerdown");
        pwdn_req = 0;
        @(negedge clk);
        chk("R6", pwr_down, 0, "powerdown released");
        chk("R6", pump_hiz, 0, "hiz released after powerdown");
        pwdn_req = 1;
        @(negedge clk);
        chk("R6", pwr_down, 1, "idle powerdown immediate");
        pwdn_req = 0;
        repeat (2) @(negedge clk);

        chk("R1", expq.size(), 0, "scoreboard drained");
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R13 watchdog expired: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule